// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block watches a bank of external input lines and turns their edges into interrupt and event requests. Software chooses, for each line, whether a rising edge, a falling edge or both should count. It also chooses whether the line may raise an interrupt and whether it may raise an event. A recorded interrupt stays pending until software clears it by writing a one to its bit. Software can also raise a line's interrupt directly through a trigger register.

Each line first passes through an edge catcher. The catcher holds a pair of flip-flops clocked by the line itself, one for each edge direction, so an edge is caught even when the pulse is shorter than a system clock period. The caught edge then passes through a two-stage synchronizer into the clock domain. Once the synchronized edge has been recorded, the catcher is cleared asynchronously. Edges that arrive while this clear is in progress merge into the edge already being reported.

Top module: `edge_irq_bank`

## Requirements
- R1: A rising edge on a line whose rising enable bit is set, and whose interrupt mask bit is set, sets that line's pending bit no later than the third clock edge after the input edge.
- R2: A falling edge on a line whose falling enable bit is set, and whose interrupt mask bit is set, sets its pending bit. With both enables set, the rising edge and the later falling edge each set pending again after a clear.
- R3: An edge in a direction whose enable bit is clear leaves the pending bit at 0.
- R4: With a line's interrupt mask bit at 0, neither an edge nor a software trigger sets its pending bit. The output `irq_o` equals pending AND interrupt mask, bit by bit.
- R5: A high pulse shorter than one clock period, with both of its edges between two clock edges, is still recorded as pending when either of its edge directions is enabled.
- R6: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: Writing the software trigger register sets the pending bits written as 1, for lines whose interrupt mask bit is set, at the clock edge of the write. This register reads back as 0.
- R8: `evt_o` pulses high for exactly one cycle for each captured edge or software trigger on a line whose event mask bit is set, whatever that line's interrupt mask is. For a software trigger the pulse is visible after the clock edge of the write.
- R9: Rewriting the enable or mask registers does not clear a pending bit.
- R10: After reset every register reads 0 and `irq_o` and `evt_o` are 0. The register select values are: 0 rising enable, 1 falling enable, 2 interrupt mask, 3 event mask, 4 pending, 5 software trigger. Writes to values 0 to 3 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | NLINES | External lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select for both read and write |
| wdata_i | input | NLINES | Write data, one bit per line |
| rdata_o | output | NLINES | Read data of the selected register |
| irq_o | output | NLINES | Interrupt requests per line |
| evt_o | output | NLINES | One-cycle event pulses per line |

## Verification
The bench concentrates on pulses that fall entirely between two clock edges. A design that sampled the line synchronously would miss them and leave pending at 0. It drives lines that are already high when their rising enable is switched on, so a catcher that registered levels instead of edges would raise a false pending. It checks that writing zeros to the pending register and rewriting the configuration both leave pending intact, which a plain register write would break. Finally, it counts event pulses per edge: a catcher that was never cleared, or a pulse taken from a level, would produce several cycles of event instead of one.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_RISE  = 3'd0,
    SEL_FALL  = 3'd1,
    SEL_IMASK = 3'd2,
    SEL_EMASK = 3'd3,
    SEL_PEND  = 3'd4,
    SEL_SWTRG = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/edge_catch.sv
module edge_catch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic pulse_o
);
  logic rise_q, fall_q;
  logic sync1_q, sync2_q, ack_q;
  logic clr_async;

  // catcher is released only once the synchronized copy has been seen
  assign clr_async = ack_q | ~rst_ni;

  always_ff @(posedge line_i or posedge clr_async) begin
    if (clr_async)      rise_q <= 1'b0;
    else if (rise_en_i) rise_q <= 1'b1;
  end

  always_ff @(negedge line_i or posedge clr_async) begin
    if (clr_async)      fall_q <= 1'b0;
    else if (fall_en_i) fall_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      sync1_q <= rise_q | fall_q;
      sync2_q <= sync1_q;
      ack_q   <= sync2_q;
    end
  end

  assign pulse_o = sync2_q & ~ack_q;

  AST_CATCH_HELD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && $past(ack_q)) |-> !(rise_q || fall_q)); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R8
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NLINES-1:0] wdata_i,
  output logic [NLINES-1:0] rdata_o,
  input  logic [NLINES-1:0] pulse_i,
  output logic [NLINES-1:0] rise_en_o,
  output logic [NLINES-1:0] fall_en_o,
  output logic [NLINES-1:0] irq_o,
  output logic [NLINES-1:0] evt_o
);
  logic [NLINES-1:0] rise_q, fall_q, imask_q, emask_q, pend_q, evt_q;
  logic [NLINES-1:0] sw_vec, clr_vec, trig_vec, set_vec;

  function automatic logic [NLINES-1:0] pend_next(
    input logic [NLINES-1:0] cur, input logic [NLINES-1:0] set,
    input logic [NLINES-1:0] clr);
    // a new trigger wins over a clear in the same cycle
    return (cur & ~clr) | set;
  endfunction

  assign sw_vec   = (wr_en_i && addr_i == SEL_SWTRG) ? wdata_i : '0;
  assign clr_vec  = (wr_en_i && addr_i == SEL_PEND)  ? wdata_i : '0;
  assign trig_vec = pulse_i | sw_vec;
  assign set_vec  = trig_vec & imask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      fall_q  <= '0;
      imask_q <= '0;
      emask_q <= '0;
      pend_q  <= '0;
      evt_q   <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          SEL_RISE:  rise_q  <= wdata_i;
          SEL_FALL:  fall_q  <= wdata_i;
          SEL_IMASK: imask_q <= wdata_i;
          SEL_EMASK: emask_q <= wdata_i;
          default: ;
        endcase
      end
      pend_q <= pend_next(pend_q, set_vec, clr_vec);
      evt_q  <= trig_vec & emask_q;
    end
  end

  always_comb begin
    case (addr_i)
      SEL_RISE:  rdata_o = rise_q;
      SEL_FALL:  rdata_o = fall_q;
      SEL_IMASK: rdata_o = imask_q;
      SEL_EMASK: rdata_o = emask_q;
      SEL_PEND:  rdata_o = pend_q;
      default:   rdata_o = '0;
    endcase
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign irq_o     = pend_q & imask_q;
  assign evt_o     = evt_q;

  AST_PEND_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0)); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_PEND) |=> ((pend_q & $past(wdata_i & ~set_vec)) == '0)); // R6

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0)); // R9
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
  import edge_irq_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] line_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NLINES-1:0] wdata_i,
  output logic [NLINES-1:0] rdata_o,
  output logic [NLINES-1:0] irq_o,
  output logic [NLINES-1:0] evt_o
);
  logic [NLINES-1:0] pulse_vec, rise_en, fall_en;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    edge_catch u_catch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (line_i[g]),
      .rise_en_i (rise_en[g]),
      .fall_en_i (fall_en[g]),
      .pulse_o   (pulse_vec[g])
    );
  end

  irq_regs #(.NLINES(NLINES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pulse_i   (pulse_vec),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .irq_o     (irq_o),
    .evt_o     (evt_o)
  );
endmodule

// File: tb/test_edge_irq_bank.sv
`timescale 1ns/1ps
module test_edge_irq_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_r = '0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, irq, evt;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  edge_irq_bank #(.NLINES(8)) i_edge_irq_bank (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_r), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .evt_o(evt)
  );

  // fields: rise, fall, imask, lines, kind, expected pending
  // kind 0: wide pulse, 1: narrow pulse, 2: stays high, 3: starts high then falls
  localparam logic [41:0] VEC [9] = '{
    {8'h01, 8'h00, 8'hFF, 8'h01, 2'd2, 8'h01},  // R1
    {8'h00, 8'h02, 8'hFF, 8'h02, 2'd3, 8'h02},  // R2
    {8'h04, 8'h00, 8'hFF, 8'h04, 2'd3, 8'h00},  // R3
    {8'h0F, 8'h00, 8'h05, 8'h0F, 2'd2, 8'h05},  // R4
    {8'h10, 8'h20, 8'hFF, 8'h30, 2'd1, 8'h30},  // R5
    {8'h00, 8'h80, 8'hFF, 8'hC0, 2'd0, 8'h80},  // R3
    {8'hFF, 8'hFF, 8'hFF, 8'hAA, 2'd1, 8'hAA},  // R5
    {8'h40, 8'h00, 8'h00, 8'h40, 2'd2, 8'h00},  // R4
    {8'h00, 8'h01, 8'hFF, 8'h01, 2'd1, 8'h01}   // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #2 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    for (int a = 0; a < 6; a++) begin
      rd_reg(a[2:0], v);
      check("R10 reset register", v, 8'h00);
    end
    check("R10 reset irq_o", irq, 8'h00);
    check("R10 reset evt_o", evt, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R10: read back of configuration registers
    wr_reg(3'd0, 8'h5A); wr_reg(3'd1, 8'hA5); wr_reg(3'd2, 8'h3C); wr_reg(3'd3, 8'hC3);
    rd_reg(3'd0, v); check("R10 rise readback", v, 8'h5A);
    rd_reg(3'd1, v); check("R10 fall readback", v, 8'hA5);
    rd_reg(3'd2, v); check("R10 imask readback", v, 8'h3C);
    rd_reg(3'd3, v); check("R10 emask readback", v, 8'hC3);
    wr_reg(3'd3, 8'h00);

    // table walk
    foreach (VEC[k]) begin
      logic [7:0] re, fe, im, ln, ex;
      logic [1:0] kind;
      {re, fe, im, ln, kind, ex} = VEC[k];
      wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00);
      line_r = (kind == 2'd3) ? ln : 8'h00;
      idle(8);
      wr_reg(3'd4, 8'hFF);
      wr_reg(3'd2, im); wr_reg(3'd0, re); wr_reg(3'd1, fe);
      @(negedge clk);
      case (kind)
        2'd0: begin line_r = line_r | ln; idle(2); line_r = line_r & ~ln; end
        2'd1: begin #1 line_r = line_r | ln; #3 line_r = line_r & ~ln; end
        2'd2: line_r = line_r | ln;
        default: line_r = line_r & ~ln;
      endcase
      idle(5);
      rd_reg(3'd4, v);
      check($sformatf("R1 R2 R3 R4 R5 vector %0d pending", k), v, ex);
      check($sformatf("R4 vector %0d irq_o", k), irq, ex & im);
      wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00);
      line_r = 8'h00;
      idle(8);
    end

    // R2: both edges each trigger
    wr_reg(3'd4, 8'hFF); wr_reg(3'd2, 8'hFF);
    wr_reg(3'd0, 8'h08); wr_reg(3'd1, 8'h08);
    line_r = 8'h08; idle(8);
    rd_reg(3'd4, v); check("R2 rising with both enabled", v, 8'h08);
    wr_reg(3'd4, 8'h08);
    rd_reg(3'd4, v); check("R6 cleared before falling edge", v, 8'h00);
    line_r = 8'h00; idle(8);
    rd_reg(3'd4, v); check("R2 falling with both enabled", v, 8'h08);

    // R9: configuration rewrite keeps pending
    wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00); wr_reg(3'd3, 8'hFF);
    rd_reg(3'd4, v); check("R9 pending after config rewrite", v, 8'h08);
    wr_reg(3'd2, 8'h00);
    rd_reg(3'd4, v); check("R9 pending after mask rewrite", v, 8'h08);
    check("R4 irq_o masked", irq, 8'h00);
    wr_reg(3'd2, 8'hFF);
    check("R4 irq_o unmasked", irq, 8'h08);
    wr_reg(3'd3, 8'h00);

    // R6: write one to clear, zero no effect
    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd5, 8'h0F);
    rd_reg(3'd4, v); check("R7 software trigger", v, 8'h0F);
    wr_reg(3'd4, 8'h05);
    rd_reg(3'd4, v); check("R6 partial clear", v, 8'h0A);
    wr_reg(3'd4, 8'h00);
    rd_reg(3'd4, v); check("R6 zero write no effect", v, 8'h0A);
    wr_reg(3'd4, 8'hFF);

    // R7: masked lines ignore software trigger, register reads 0
    wr_reg(3'd2, 8'h0F);
    wr_reg(3'd5, 8'hF1);
    rd_reg(3'd4, v); check("R7 only unmasked lines", v, 8'h01);
    rd_reg(3'd5, v); check("R7 trigger reads zero", v, 8'h00);
    wr_reg(3'd4, 8'hFF);

    // R8: software event pulse, independent of interrupt mask
    wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h03);
    @(negedge clk); wr = 1'b1; addr = 3'd5; wdata = 8'h03;
    @(negedge clk); wr = 1'b0;
    #2 check("R8 software event pulse", evt, 8'h03);
    @(negedge clk); #2 check("R8 event pulse one cycle", evt, 8'h00);
    rd_reg(3'd4, v); check("R8 masked irq no pending", v, 8'h00);

    // R8: hardware edge gives exactly one event cycle
    wr_reg(3'd3, 8'h04); wr_reg(3'd0, 8'h04);
    cnt = 0;
    line_r = 8'h04;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #2 if (evt[2]) cnt++;
    end
    check("R8 one event per edge", 8'(cnt), 8'd1);
    rd_reg(3'd4, v); check("R8 event without irq pending", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule